// File: doc/BRIEF.md
# Configuration EEPROM Command Controller

This block fronts a 128-byte non-volatile configuration store that holds a board's station (MAC) address. Software drives it through two 32-bit registers. The command register carries an opcode and a byte address. The data register carries one byte, either going into the store or coming out of it. Each command write runs in a single clock. It reads a byte, sets or clears the write-enable latch, programs bits, erases, or reloads the station address. The storage is modelled as an on-chip byte array. Programming can only clear bits, as a cell does when it is programmed without an erase. Only an erase brings bits back to one.

The reload step protects the station address. The first byte must hold the signature 0xA5 before the next six bytes are copied to the `station_addr` output. A blank store, or one that has been partly erased, therefore never puts a half-formed address on the port. A reload runs by itself on the first clock after reset, and software can request another one at any time.

Top module: `eep_cmd_ctrl`

## Requirements
- R1: A command-register write (`reg_wr_sel`=0) takes its opcode from bits 30:28 and its byte address from bits 6:0. All other bits are ignored. Opcodes: 0 read, 1 write-disable, 2 write-enable, 3 program, 4 program-all, 5 erase, 6 erase-all, 7 reload. The command view (`reg_rd_sel`=0) returns the last opcode in bits 30:28 and the last address in bits 22:16. All other bits except bit 4 read as zero.
- R2: A data-register write (`reg_wr_sel`=1) keeps only bits 7:0. The data view (`reg_rd_sel`=1) returns that byte zero-extended to 32 bits.
- R3: A read command copies the addressed byte into the data register. The new value is visible from the clock edge that accepts the command.
- R4: Write-enable sets the write-enable latch. Write-disable and reset clear it.
- R5: While the latch is clear, program, program-all, erase and erase-all leave every byte of the store unchanged.
- R6: With the latch set, program ANDs the data register into the addressed byte, and program-all ANDs it into all 128 bytes.
- R7: With the latch set, erase sets the addressed byte to 0xFF, and erase-all sets every byte to 0xFF.
- R8: Reload checks byte 0. If it equals 0xA5, `station_addr[8k+7:8k]` receives byte k+1 for k = 0..5 and `addr_loaded` goes to 1. Otherwise `addr_loaded` goes to 0 and `station_addr` keeps its value.
- R9: Reset loads the power-up image into the store (0xA5, then the six bytes of `STATION_INIT` with its low byte first, then 0xFF). Reset also clears the data and command registers and runs a reload on the first clock after reset is released.
- R10: Bit 4 of the command view equals `addr_loaded`. It keeps its value through every command other than reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe, one cycle per access |
| reg_wr_sel | input | 1 | Write target: 0 command, 1 data |
| reg_wr_data | input | 32 | Write value |
| reg_rd_sel | input | 1 | Read view: 0 command, 1 data |
| reg_rd_data | output | 32 | Selected register view (combinational) |
| station_addr | output | 48 | Station address taken from the last successful reload |
| addr_loaded | output | 1 | Last reload found a valid signature |

## Verification
Random command streams are mixed with random data bytes and random filler in the ignored command bits. This shows whether the decode really uses only bits 30:28 and 6:0, and whether program-only-clears differs from a plain overwrite. Directed sequences then toggle the latch around each mutating command, which shows a protected store apart from a writable one. Each read-back confirms exactly one byte changed, or all of them. Reloads are run both with an intact signature and with byte 0 erased. This tells a committed address apart from a kept one, and shows whether the loaded bit survives the commands that follow.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [2:0] {
    OP_READ   = 3'd0,
    OP_WDIS   = 3'd1,
    OP_WEN    = 3'd2,
    OP_PROG   = 3'd3,
    OP_PALL   = 3'd4,
    OP_ERASE  = 3'd5,
    OP_EALL   = 3'd6,
    OP_RELOAD = 3'd7
  } eep_op_e;

  localparam int STATION_BYTES = 6;
  localparam int STATION_W     = 8 * STATION_BYTES;

  // Byte value held at a given index right after reset.
  function automatic logic [7:0] power_up_byte(input int idx,
                                               input logic [STATION_W-1:0] init,
                                               input logic [7:0] sig);
    logic [STATION_W-1:0] shifted;
    if (idx == 0) return sig;
    if (idx <= STATION_BYTES) begin
      shifted = init >> (8 * (idx - 1));
      return shifted[7:0];
    end
    return 8'hFF;
  endfunction

  function automatic logic alters_store(input eep_op_e op);
    return (op == OP_PROG) || (op == OP_PALL) || (op == OP_ERASE) || (op == OP_EALL);
  endfunction

  // Program-without-erase: a cell can only go from 1 to 0.
  function automatic logic [7:0] program_cell(input logic [7:0] old_v, input logic [7:0] d);
    return old_v & d;
  endfunction

endpackage

// File: rtl/eep_store.sv
module eep_store import eep_pkg::*; #(
  parameter int                   DEPTH        = 128,
  parameter logic [STATION_W-1:0] STATION_INIT = 48'h0,
  parameter logic [7:0]           SIGNATURE    = 8'hA5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     apply,
  input  eep_op_e                  op,
  input  logic [$clog2(DEPTH)-1:0] addr,
  input  logic [7:0]               din,
  output logic [7:0]               rd_byte,
  output logic [7:0]               sig_byte,
  output logic [STATION_W-1:0]     image
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= power_up_byte(i, STATION_INIT, SIGNATURE);
    end else if (apply) begin
      for (int i = 0; i < DEPTH; i++) begin
        unique case (op)
          OP_PROG:  if (addr == i[$clog2(DEPTH)-1:0]) mem[i] <= program_cell(mem[i], din);
          OP_PALL:  mem[i] <= program_cell(mem[i], din);
          OP_ERASE: if (addr == i[$clog2(DEPTH)-1:0]) mem[i] <= 8'hFF;
          OP_EALL:  mem[i] <= 8'hFF;
          default:  ;
        endcase
      end
    end
  end

  assign rd_byte  = mem[addr];
  assign sig_byte = mem[0];

  for (genvar k = 0; k < STATION_BYTES; k++) begin : g_image
    assign image[8*k +: 8] = mem[k+1];
  end
endmodule

// File: rtl/eep_reload.sv
module eep_reload import eep_pkg::*; #(
  parameter logic [7:0] SIGNATURE = 8'hA5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fire,
  input  logic [7:0]           sig_byte,
  input  logic [STATION_W-1:0] image,
  output logic [STATION_W-1:0] station,
  output logic                 loaded
);
  logic sig_ok;
  assign sig_ok = (sig_byte == SIGNATURE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      station <= '0;
      loaded  <= 1'b0;
    end else if (fire) begin
      loaded <= sig_ok;
      if (sig_ok) station <= image;
    end
  end
endmodule

// File: rtl/eep_cmd_ctrl.sv
module eep_cmd_ctrl import eep_pkg::*; #(
  parameter int          DEPTH        = 128,
  parameter logic [47:0] STATION_INIT = 48'h665544332211,
  parameter logic [7:0]  SIGNATURE    = 8'hA5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic        reg_wr_sel,
  input  logic [31:0] reg_wr_data,
  input  logic        reg_rd_sel,
  output logic [31:0] reg_rd_data,
  output logic [47:0] station_addr,
  output logic        addr_loaded
);
  localparam int AW = $clog2(DEPTH);

  // Named events for the checker
  logic          cmd_fire, data_fire, reload_fire, store_apply;
  eep_op_e       cmd_op;
  logic [AW-1:0] cmd_addr;
  logic [7:0]    wr_low;

  eep_op_e       op_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic          wel_q, boot_q;

  logic [7:0]           rd_byte, sig_byte;
  logic [STATION_W-1:0] image;

  assign cmd_fire    = reg_wr_en && !reg_wr_sel;
  assign data_fire   = reg_wr_en &&  reg_wr_sel;
  assign cmd_op      = eep_op_e'(reg_wr_data[30:28]);
  assign cmd_addr    = reg_wr_data[AW-1:0];
  assign wr_low      = reg_wr_data[7:0];
  assign store_apply = cmd_fire && wel_q && alters_store(cmd_op);
  assign reload_fire = boot_q || (cmd_fire && cmd_op == OP_RELOAD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= OP_READ;
      addr_q <= '0;
      data_q <= '0;
      wel_q  <= 1'b0;
      boot_q <= 1'b1;
    end else begin
      boot_q <= 1'b0;
      if (data_fire) data_q <= wr_low;
      if (cmd_fire) begin
        op_q   <= cmd_op;
        addr_q <= cmd_addr;
        if (cmd_op == OP_READ) data_q <= rd_byte;
        if (cmd_op == OP_WEN)  wel_q  <= 1'b1;
        if (cmd_op == OP_WDIS) wel_q  <= 1'b0;
      end
    end
  end

  eep_store #(.DEPTH(DEPTH), .STATION_INIT(STATION_INIT), .SIGNATURE(SIGNATURE)) u_store (
    .clk(clk), .rst_n(rst_n), .apply(store_apply), .op(cmd_op), .addr(cmd_addr),
    .din(data_q), .rd_byte(rd_byte), .sig_byte(sig_byte), .image(image)
  );

  eep_reload #(.SIGNATURE(SIGNATURE)) u_reload (
    .clk(clk), .rst_n(rst_n), .fire(reload_fire), .sig_byte(sig_byte), .image(image),
    .station(station_addr), .loaded(addr_loaded)
  );

  logic [6:0] addr_view;
  assign addr_view = 7'(addr_q);

  assign reg_rd_data = reg_rd_sel ? {24'b0, data_q}
                                  : {1'b0, op_q, 5'b0, addr_view, 11'b0, addr_loaded, 4'b0};
endmodule

// File: rtl/eep_cmd_ctrl_chk.sv
module eep_cmd_ctrl_chk import eep_pkg::*; (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmd_fire,
  input logic                 data_fire,
  input eep_op_e              cmd_op,
  input logic [7:0]           wr_low,
  input logic [7:0]           data_q,
  input logic                 wel_q,
  input logic                 boot_q,
  input logic                 reload_fire,
  input logic [7:0]           sig_byte,
  input logic [STATION_W-1:0] image,
  input logic [STATION_W-1:0] station_addr,
  input logic                 addr_loaded
);
  assert_data_low_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    data_fire |=> data_q == $past(wr_low));

  assert_latch_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && cmd_op == OP_WEN) |=> wel_q);

  assert_latch_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && cmd_op == OP_WDIS) |=> !wel_q);

  assert_protected_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && !wel_q && alters_store(cmd_op)) |=> ($stable(sig_byte) && $stable(image)));

  assert_reload_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_fire && sig_byte == 8'hA5) |=> (addr_loaded && station_addr == $past(image)));

  assert_reload_fail_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_fire && sig_byte != 8'hA5) |=> (!addr_loaded && $stable(station_addr)));

  assert_loaded_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && cmd_op != OP_RELOAD && !boot_q) |=> $stable(addr_loaded));
endmodule

bind eep_cmd_ctrl eep_cmd_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_fire(cmd_fire), .data_fire(data_fire), .cmd_op(cmd_op),
  .wr_low(wr_low), .data_q(data_q), .wel_q(wel_q), .boot_q(boot_q), .reload_fire(reload_fire),
  .sig_byte(sig_byte), .image(image), .station_addr(station_addr), .addr_loaded(addr_loaded)
);

// File: tb/eep_cmd_ctrl_test.sv
`timescale 1ns/1ps
module eep_cmd_ctrl_test;
  localparam logic [47:0] INIT = 48'h665544332211;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0, reg_wr_sel = 1'b0, reg_rd_sel = 1'b0;
  logic [31:0] reg_wr_data = '0;
  logic [31:0] reg_rd_data;
  logic [47:0] station_addr;
  logic        addr_loaded;

  int compared = 0, mismatched = 0;

  // Reference state
  logic [7:0]  m_mem [128];
  logic [7:0]  m_data;
  logic        m_wel, m_loaded;
  logic [47:0] m_station;
  logic [2:0]  m_op;
  logic [6:0]  m_addr;

  always #2.5 clk = ~clk;

  eep_cmd_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
    .reg_wr_data(reg_wr_data), .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data),
    .station_addr(station_addr), .addr_loaded(addr_loaded)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_cmd_view();
    logic [31:0] v = 32'h0;
    v[30:28] = m_op;
    v[22:16] = m_addr;
    v[4]     = m_loaded;
    return v;
  endfunction

  task automatic model_reload();
    if (m_mem[0] == 8'hA5) begin
      m_loaded = 1'b1;
      m_station = {m_mem[6], m_mem[5], m_mem[4], m_mem[3], m_mem[2], m_mem[1]};
    end else m_loaded = 1'b0;
  endtask

  task automatic model_reset();
    for (int i = 0; i < 128; i++) m_mem[i] = 8'hFF;
    m_mem[0] = 8'hA5;
    for (int k = 0; k < 6; k++) m_mem[k+1] = INIT[8*k +: 8];
    m_data = 0; m_wel = 0; m_op = 0; m_addr = 0; m_station = 0; m_loaded = 0;
    model_reload();
  endtask

  task automatic compare_all(input string tag);
    reg_rd_sel = 1'b0; #0.5;
    check({tag, " R1 R10 cmd view"}, {32'h0, reg_rd_data}, {32'h0, exp_cmd_view()});
    reg_rd_sel = 1'b1; #0.5;
    check({tag, " R2 R3 data view"}, {32'h0, reg_rd_data}, {56'h0, m_data});
    check({tag, " R8 station"}, {16'h0, station_addr}, {16'h0, m_station});
    check({tag, " R8 loaded"}, {63'h0, addr_loaded}, {63'h0, m_loaded});
  endtask

  task automatic put_data(input logic [31:0] v);
    @(negedge clk);
    reg_wr_en = 1; reg_wr_sel = 1; reg_wr_data = v;
    @(negedge clk);
    reg_wr_en = 0;
    m_data = v[7:0];
  endtask

  task automatic issue(input logic [2:0] op, input logic [6:0] a, input logic [31:0] filler);
    logic [31:0] w = filler;
    w[30:28] = op;
    w[6:0]   = a;
    @(negedge clk);
    reg_wr_en = 1; reg_wr_sel = 0; reg_wr_data = w;
    @(negedge clk);
    reg_wr_en = 0;
    m_op = op; m_addr = a;
    case (op)
      3'd0: m_data = m_mem[a];
      3'd1: m_wel = 0;
      3'd2: m_wel = 1;
      3'd3: if (m_wel) m_mem[a] = m_mem[a] & m_data;
      3'd4: if (m_wel) for (int i = 0; i < 128; i++) m_mem[i] = m_mem[i] & m_data;
      3'd5: if (m_wel) m_mem[a] = 8'hFF;
      3'd6: if (m_wel) for (int i = 0; i < 128; i++) m_mem[i] = 8'hFF;
      default: model_reload();
    endcase
  endtask

  task automatic read_check(input logic [6:0] a, input logic [7:0] exp, input string req);
    issue(3'd0, a, 32'h0);
    reg_rd_sel = 1'b1; #0.5;
    check(req, {32'h0, reg_rd_data}, {56'h0, exp});
  endtask

  initial begin
    #(5.0 * 150000);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R9: reset state and automatic reload
    compare_all("reset R9");
    check("R9 station after reset", {16'h0, station_addr}, {16'h0, INIT});
    read_check(7'd0, 8'hA5, "R9 byte0 image");
    read_check(7'd127, 8'hFF, "R9 tail byte image");

    // R5: protected store ignores mutations
    put_data(32'h0000_0000);
    issue(3'd5, 7'd1, 32'h0); issue(3'd3, 7'd2, 32'h0); issue(3'd6, 7'd0, 32'h0);
    read_check(7'd1, INIT[7:0], "R5 erase ignored");
    read_check(7'd2, INIT[15:8], "R5 program ignored");
    // R4 / R6: program clears bits only
    issue(3'd2, 7'd0, 32'h0);
    put_data(32'hABCD_120F);
    compare_all("R2 data truncation");
    issue(3'd3, 7'd10, 32'h0);
    read_check(7'd10, 8'h0F, "R6 program AND");
    put_data(32'h0000_00F3);
    issue(3'd3, 7'd10, 32'h0);
    read_check(7'd10, 8'h03, "R6 program clears only");
    // R7 single erase
    issue(3'd5, 7'd10, 32'h0);
    read_check(7'd10, 8'hFF, "R7 erase byte");
    // R8 failing reload keeps station
    issue(3'd5, 7'd0, 32'h0);
    issue(3'd7, 7'd0, 32'h0);
    compare_all("R8 bad signature");
    check("R8 station kept", {16'h0, station_addr}, {16'h0, INIT});
    issue(3'd0, 7'd9, 32'h0);
    compare_all("R10 loaded held");
    // rewrite signature and address, reload
    put_data(32'hA5); issue(3'd3, 7'd0, 32'h0);
    for (int k = 1; k <= 6; k++) begin
      issue(3'd5, 7'(k), 32'h0);
      put_data(32'(8'h10 * k + 8'h0A)); issue(3'd3, 7'(k), 32'h0);
    end
    issue(3'd7, 7'd0, 32'h0);
    compare_all("R8 good reload");
    check("R8 new station", {16'h0, station_addr}, {16'h0, 48'h6A5A4A3A2A1A});
    // R4 disable then erase-all ignored
    issue(3'd1, 7'd0, 32'h0);
    issue(3'd6, 7'd0, 32'h0);
    read_check(7'd3, 8'h3A, "R4 R5 erase-all ignored");
    // R7 / R6 whole-array operations
    issue(3'd2, 7'd0, 32'h0);
    issue(3'd6, 7'd0, 32'h0);
    read_check(7'd64, 8'hFF, "R7 erase-all");
    put_data(32'h3C); issue(3'd4, 7'd0, 32'h0);
    read_check(7'd99, 8'h3C, "R6 program-all");
    read_check(7'd0, 8'h3C, "R6 program-all byte0");

    // Random stream with filler in ignored bits (R1)
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r = $urandom;
      if (r[3:0] == 4'd0) begin
        put_data($urandom);
        compare_all("rand R2");
      end else begin
        logic [2:0] op = 3'($urandom_range(0, 7));
        if (r[4] && op > 3'd3) op = 3'd0;
        issue(op, 7'($urandom_range(0, 127)), $urandom);
        compare_all("rand R1");
      end
      if (r[31:24] == 8'd7) begin
        issue(3'd2, 7'd0, 32'h0);
        issue(3'd6, 7'd0, 32'h0);
        put_data(32'hA5); issue(3'd3, 7'd0, 32'h0);
      end
    end
    for (int i = 0; i < 128; i += 9) read_check(7'(i), m_mem[i], "final R3 array sweep");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule